// File: doc/BRIEF.md
# Split Coarse/Fine Oscillator Tuning Encoder with Fractional Dither

This block turns a digital oscillator tuning word into the switch controls of a tunable element bank. The word holds three fields. The most significant field drives a binary-weighted coarse bank bit for bit. The middle field is turned into a thermometer code for a bank of identical unit elements, so each increment of that field switches on exactly one more unit. The least significant field feeds a first-order accumulator. On each cycle where that accumulator carries, one extra unit element is switched on. Over many cycles of the fast clock, the average fine setting therefore lands between two unit steps.

A control loop presents a new word together with a one-cycle load strobe. The block keeps that word until the next strobe. The coarse and fine outputs are registered together, so both banks change on the same clock edge. The enable input lets the accumulator run. While enable is low, the accumulator holds its residue and no extra unit is added. A load does not clear the accumulator, so the running dither phase carries across word updates.

Top module: `dco_tune_encoder`

## Requirements
- R1: While reset is asserted, the coarse vector, the fine vector and the accumulator are all zero.
- R2: The tuning word splits as follows. The coarse field is bits [CW+FW+RW-1:FW+RW], the fine field is bits [FW+RW-1:RW] and the fractional field is bits [RW-1:0]. On the edge where load is high, the coarse output takes the coarse field of the presented word.
- R3: When load is low, changes on the tuning word input have no effect. The coarse output and the fine integer setting keep the last loaded word.
- R4: After every edge, the fine vector is a thermometer code whose ones are contiguous from bit 0. Its number of ones equals the loaded fine field plus the dither bit for that cycle.
- R5: With enable high and the word held, any 2^RW consecutive cycles contain exactly as many dither bits as the value of the fractional field.
- R6: When the fine field is at its maximum and a dither bit occurs, all 2^FW fine elements are on. The count never wraps to a smaller value.
- R7: While enable is low, no dither bit is added and the accumulator residue is held. The fine count then equals the loaded fine field.
- R8: A zero fractional field never produces a dither bit.
- R9: The accumulator is not cleared by a load. The dither sequence after a load continues from the residue left before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Lets the fractional accumulator run |
| load | input | 1 | Captures tune_word on this edge |
| tune_word | input | CW+FW+RW | Coarse, fine and fractional fields |
| coarse_o | output | CW | Binary-weighted coarse bank controls |
| fine_o | output | 2^FW | Unit-element thermometer controls |

## Verification
On every cycle, the assertions check the following: the fine vector stays a thermometer code with its ones contiguous from bit 0; its count never moves more than one unit away from the loaded fine field; the coarse output holds between load strobes; and no dither bit appears while enable is low or when the fraction is zero. The exact dither density over a full accumulator period, the all-ones case at the top of the fine range, and the way the residue carries across a load depend on history over many cycles. Only the bench scenarios show these, by comparing each cycle with the bench's own model.

// File: rtl/dco_enc_pkg.sv
package dco_enc_pkg;
    localparam int DEF_CW = 4;
    localparam int DEF_FW = 3;
    localparam int DEF_RW = 4;
endpackage

// File: rtl/frac_dither.sv
module frac_dither #(
    parameter int RW = 4
) (
    input  logic          run,
    input  logic [RW-1:0] acc_q,
    input  logic [RW-1:0] frac,
    output logic [RW-1:0] acc_d,
    output logic          carry
);
    logic [RW:0] sum;

    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, frac};
        acc_d = run ? sum[RW-1:0] : acc_q;
        carry = run & sum[RW];
    end

    always_comb begin
        if (frac == '0) begin
            a_r8_zero_frac_no_carry: assert (!carry);
        end
    end
endmodule

// File: rtl/therm_enc.sv
module therm_enc #(
    parameter int FW = 3,
    localparam int NU = 1 << FW
) (
    input  logic [FW:0]   count,
    output logic [NU-1:0] therm
);
    for (genvar i = 0; i < NU; i++) begin : g_unit
        assign therm[i] = (count > (FW+1)'(i));
    end
endmodule

// File: rtl/dco_tune_encoder.sv
module dco_tune_encoder
    import dco_enc_pkg::*;
#(
    parameter int CW = DEF_CW,
    parameter int FW = DEF_FW,
    parameter int RW = DEF_RW,
    localparam int TW = CW + FW + RW,
    localparam int NU = 1 << FW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          load,
    input  logic [TW-1:0] tune_word,
    output logic [CW-1:0] coarse_o,
    output logic [NU-1:0] fine_o
);
    typedef struct packed {
        logic [TW-1:0] word;
        logic [RW-1:0] acc;
        logic [CW-1:0] coarse;
        logic [NU-1:0] fine;
    } state_t;

    state_t st_q, st_d;

    logic [TW-1:0] word_sel;
    logic [RW-1:0] acc_nx;
    logic          dither;
    logic [FW:0]   unit_cnt;
    logic [NU-1:0] therm_nx;

    assign word_sel = load ? tune_word : st_q.word;

    frac_dither #(.RW(RW)) u_dither (
        .run   (en),
        .acc_q (st_q.acc),
        .frac  (word_sel[RW-1:0]),
        .acc_d (acc_nx),
        .carry (dither)
    );

    assign unit_cnt = {1'b0, word_sel[FW+RW-1:RW]} + {{FW{1'b0}}, dither};

    therm_enc #(.FW(FW)) u_therm (
        .count (unit_cnt),
        .therm (therm_nx)
    );

    always_comb begin
        st_d        = st_q;
        st_d.word   = word_sel;
        st_d.acc    = acc_nx;
        st_d.coarse = word_sel[TW-1:FW+RW];
        st_d.fine   = therm_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign coarse_o = st_q.coarse;
    assign fine_o   = st_q.fine;

    logic [FW:0] held_fine;
    assign held_fine = {1'b0, st_q.word[FW+RW-1:RW]};

    a_r2_load_coarse: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> coarse_o == $past(tune_word[TW-1:FW+RW]));
    a_r3_hold_coarse: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(coarse_o));
    a_r4_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_o & (fine_o + 1'b1)) == '0);
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(fine_o) == int'(held_fine)) ||
        ($countones(fine_o) == int'(held_fine) + 1));
    a_r7_idle_no_dither: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $countones(fine_o) == int'(held_fine));
endmodule

// File: tb/sim_dco_tune_encoder.sv
module sim_dco_tune_encoder;
    localparam int CW = 4, FW = 3, RW = 4;
    localparam int TW = CW + FW + RW, NU = 1 << FW;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 0, rst_n = 0, en = 0, load = 0;
    logic [TW-1:0] tune_word = '0;
    logic [CW-1:0] coarse_o;
    logic [NU-1:0] fine_o;

    int checks = 0, failures = 0;
    int m_word = 0, m_acc = 0, m_carry = 0;
    int carry_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    dco_tune_encoder #(.CW(CW), .FW(FW), .RW(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .load(load),
        .tune_word(tune_word), .coarse_o(coarse_o), .fine_o(fine_o));

    function automatic int mk(int c, int f, int r);
        return (c << (FW+RW)) | (f << RW) | r;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one clock: update reference model at the edge, compare at the next falling edge
    task automatic cyc(string tag);
        int cnt;
        @(posedge clk);
        if (!rst_n) begin
            m_word = 0; m_acc = 0; m_carry = 0;
        end else begin
            if (load) m_word = int'(tune_word);
            m_carry = 0;
            if (en) begin
                m_acc   = m_acc + (m_word % (1 << RW));
                m_carry = m_acc >> RW;
                m_acc   = m_acc % (1 << RW);
            end
        end
        @(negedge clk);
        cnt = ((m_word >> RW) % NU) + m_carry;
        if (!rst_n) cnt = 0;
        check({tag, " coarse"}, int'(coarse_o), rst_n ? (m_word >> (FW+RW)) : 0);
        check({tag, " fine"}, int'(fine_o), (1 << cnt) - 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        tune_word = TW'(mk(9, 5, 7)); load = 1; en = 1;
        cyc("R1 reset"); cyc("R1 reset");
        load = 0; en = 0; rst_n = 1;
        cyc("R1 idle after reset");

        // R2: load a word and check field placement
        tune_word = TW'(mk(10, 3, 0)); load = 1; en = 1;
        cyc("R2 load");
        load = 0;
        for (int i = 0; i < 4; i++) cyc("R8 zero fraction");

        // R3: input changes without load are ignored
        tune_word = TW'(mk(5, 6, 9));
        for (int i = 0; i < 4; i++) cyc("R3 no load");

        // R5: exact dither density over 2^RW cycles for several fractions
        for (int fr = 1; fr < (1 << RW); fr += 4) begin
            tune_word = TW'(mk(fr % 16, 2, fr)); load = 1;
            cyc("R5 load");
            load = 0;
            carry_cnt = 0;
            for (int i = 0; i < (1 << RW); i++) begin
                cyc("R5 dither");
                carry_cnt += $countones(fine_o) - 2;
            end
            check("R5 density", carry_cnt, fr);
        end

        // R6: fine field at maximum, dither lights every element
        tune_word = TW'(mk(15, NU-1, (1 << RW) - 1)); load = 1;
        cyc("R6 load");
        load = 0;
        for (int i = 0; i < 6; i++) begin
            cyc("R6 top");
            checks++;
            if ($countones(fine_o) < NU-1) begin
                failures++;
                $display("FAIL R6 actual=%0d expected>=%0d", $countones(fine_o), NU-1);
            end
        end

        // R7: enable low holds residue, no dither
        tune_word = TW'(mk(1, 4, 11)); load = 1;
        cyc("R7 load");
        load = 0; en = 0;
        for (int i = 0; i < 5; i++) cyc("R7 idle");
        en = 1;
        for (int i = 0; i < 6; i++) cyc("R7 resume");

        // R9: residue carries across a load
        tune_word = TW'(mk(2, 1, 13)); load = 1;
        cyc("R9 load");
        load = 0;
        for (int i = 0; i < 8; i++) cyc("R9 continue");

        // R4: walk every fine value with a mid fraction
        for (int f = 0; f < NU; f++) begin
            tune_word = TW'(mk(f, f, 8)); load = 1;
            cyc("R4 walk");
            load = 0;
            cyc("R4 walk");
        end

        // R1 again: reset mid-run
        rst_n = 0;
        cyc("R1 mid reset");
        rst_n = 1;
        cyc("R1 after reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule